// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per cycle, which hardware threads may use the instruction fetch slots. A slot is a single request for a thread, and a cycle has up to `NUM_FETCH` of them. A thread can be picked only if its active bit is set and its fetch status is one of the states from which fetch can proceed. A static two-bit policy input chooses how the block picks among eligible threads. In single-thread mode thread 0 always gets the slot. In round-robin mode a registered priority order decides. In the two occupancy modes, the thread with the smallest issue-queue count or the smallest load/store-queue count wins.

The grants are combinational from the current inputs and the registered priority order. When round-robin mode grants one or more threads, the priority order is rewritten at the next clock edge. Each granted thread moves to the back of the order, in the order the grants were made. The other threads close ranks in front and keep their relative order. A thread granted to an earlier slot in a cycle is never offered to a later slot in the same cycle. When nothing is eligible, the block reports no grant. When only one thread is configured, the policy input plays no part.

Top module: `fsel_thread_select`

## Requirements
- R1: A thread is eligible only if its `active_i` bit is 1 and its 3-bit status field `status_i[3t+2:3t]` holds 0 (running), 1 (idle) or 2 (cache line returned). Codes 3 to 7 are squashing, blocked, waiting for a cache response, waiting for a cache retry and trap-pending. A thread with any of these codes, or with its active bit at 0, is never granted. This does not apply in single-thread mode.
- R2: After reset the priority order is thread 0, 1, ..., `NUM_THREADS`-1. The first round-robin grants therefore go to the lowest-indexed eligible threads.
- R3: In round-robin mode (`policy_i`=1), each slot grants the first eligible thread in the priority order that no earlier slot has taken this cycle.
- R4: At the clock edge after a round-robin cycle with grants, the granted threads move to the back of the priority order, in slot order. All other threads keep their relative order.
- R5: In occupancy mode each slot grants the eligible thread, not yet taken this cycle, with the smallest count. `policy_i`=2 uses `iq_cnt_i` and `policy_i`=3 uses `lsq_cnt_i`, with thread t's count at bits `[CNT_W*t +: CNT_W]`. A tie goes to the lowest thread index.
- R6: Within one cycle no thread is granted to two slots. Slots fill from slot 0 upward, so `grant_valid_o[k]` implies `grant_valid_o[k-1]`. Slot k's thread index is at `grant_tid_o[TID_W*k +: TID_W]`.
- R7: If no thread is eligible, every `grant_valid_o` bit is 0 and every thread-index field is 0. An invalid slot always shows index 0.
- R8: In single-thread mode (`policy_i`=0) with more than one thread configured, slot 0 grants thread 0 whatever its status and active bit, and all later slots grant nothing.
- R9: With `NUM_THREADS`=1 the policy input is ignored. Slot 0 grants thread 0 exactly when it is eligible by R1, and all later slots grant nothing.
- R10: The priority order does not change while `policy_i` is not 1, or in a round-robin cycle with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Selection policy: 0 single, 1 round-robin, 2 issue-queue count, 3 load/store-queue count |
| status_i | input | 3*NUM_THREADS | Per-thread fetch status codes |
| active_i | input | NUM_THREADS | Per-thread active mask |
| iq_cnt_i | input | CNT_W*NUM_THREADS | Per-thread issue-queue occupancy |
| lsq_cnt_i | input | CNT_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| grant_valid_o | output | NUM_FETCH | Per-slot grant flag |
| grant_tid_o | output | TID_W*NUM_FETCH | Per-slot granted thread index |

## Verification
The two functions that fall in the same cycle are the multi-slot grant and the rewrite of the round-robin priority order. Every round-robin cycle that grants both slots makes two threads move to the back together, and the order in which they land must follow slot order. The bench provokes this by holding all threads eligible for several cycles, where the expected pattern 0,1 then 2,3 then 0,1 is known. It also runs long stretches of random status, active and policy mixes, and a queue-based reference model judges every slot of every cycle. A wrong rotation in one cycle shows up as a wrong grant in a later cycle.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    typedef enum logic [1:0] {
        POL_SINGLE = 2'd0,
        POL_RR     = 2'd1,
        POL_IQ     = 2'd2,
        POL_LSQ    = 2'd3
    } fsel_policy_e;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_CACHE_DONE = 3'd2,
        ST_SQUASH     = 3'd3,
        ST_BLOCKED    = 3'd4,
        ST_WAIT_RESP  = 3'd5,
        ST_WAIT_RETRY = 3'd6,
        ST_TRAP       = 3'd7
    } fsel_status_e;

    localparam int STATUS_W = 3;

    // States from which a thread may issue a fetch (R1)
    function automatic logic status_can_fetch(input logic [STATUS_W-1:0] s);
        return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_CACHE_DONE);
    endfunction

endpackage

// File: rtl/fsel_eligibility.sv
module fsel_eligibility #(
    parameter int NUM_THREADS = 4
) (
    input  logic [fsel_pkg::STATUS_W*NUM_THREADS-1:0] status_i,
    input  logic [NUM_THREADS-1:0]                    active_i,
    output logic [NUM_THREADS-1:0]                    elig_o
);
    import fsel_pkg::*;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign elig_o[t] = active_i[t] &&
                           status_can_fetch(status_i[STATUS_W*t +: STATUS_W]);
    end

endmodule

// File: rtl/fsel_rr_pick.sv
module fsel_rr_pick #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_FETCH   = 2,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0][TID_W-1:0] order_i,
    input  logic [NUM_THREADS-1:0]            elig_i,
    output logic [NUM_FETCH-1:0]              valid_o,
    output logic [NUM_FETCH-1:0][TID_W-1:0]   tid_o,
    output logic [NUM_THREADS-1:0][TID_W-1:0] order_next_o
);

    logic [NUM_THREADS-1:0] taken;

    // Slot cascade: each slot scans the order from the front, skipping taken threads
    always_comb begin
        taken   = '0;
        valid_o = '0;
        tid_o   = '0;
        for (int k = 0; k < NUM_FETCH; k++) begin
            for (int p = 0; p < NUM_THREADS; p++) begin
                if (!valid_o[k] && elig_i[order_i[p]] && !taken[order_i[p]]) begin
                    valid_o[k] = 1'b1;
                    tid_o[k]   = order_i[p];
                end
            end
            if (valid_o[k]) begin
                taken[tid_o[k]] = 1'b1;
            end
        end
    end

    // Rotation: untaken threads close ranks, granted ones append in slot order
    always_comb begin
        int wr;
        order_next_o = order_i;
        wr = 0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            if (!taken[order_i[p]]) begin
                order_next_o[wr] = order_i[p];
                wr = wr + 1;
            end
        end
        for (int k = 0; k < NUM_FETCH; k++) begin
            if (valid_o[k] && wr < NUM_THREADS) begin
                order_next_o[wr] = tid_o[k];
                wr = wr + 1;
            end
        end
    end

endmodule

// File: rtl/fsel_occ_pick.sv
module fsel_occ_pick #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_FETCH   = 2,
    parameter int TID_W       = 2,
    parameter int CNT_W       = 6
) (
    input  logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_i,
    input  logic [NUM_THREADS-1:0]            elig_i,
    output logic [NUM_FETCH-1:0]              valid_o,
    output logic [NUM_FETCH-1:0][TID_W-1:0]   tid_o
);

    logic [NUM_THREADS-1:0] taken;
    logic [CNT_W-1:0]       best_cnt;

    // Ascending scan with strict less-than keeps the lowest index on a tie
    always_comb begin
        taken    = '0;
        valid_o  = '0;
        tid_o    = '0;
        best_cnt = '0;
        for (int k = 0; k < NUM_FETCH; k++) begin
            best_cnt = '0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (elig_i[t] && !taken[t] && (!valid_o[k] || cnt_i[t] < best_cnt)) begin
                    valid_o[k] = 1'b1;
                    tid_o[k]   = TID_W'(t);
                    best_cnt   = cnt_i[t];
                end
            end
            if (valid_o[k]) begin
                taken[tid_o[k]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsel_thread_select.sv
module fsel_thread_select #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_FETCH   = 2,
    parameter int CNT_W       = 6,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [1:0]                                policy_i,
    input  logic [fsel_pkg::STATUS_W*NUM_THREADS-1:0] status_i,
    input  logic [NUM_THREADS-1:0]                    active_i,
    input  logic [CNT_W*NUM_THREADS-1:0]              iq_cnt_i,
    input  logic [CNT_W*NUM_THREADS-1:0]              lsq_cnt_i,
    output logic [NUM_FETCH-1:0]                      grant_valid_o,
    output logic [TID_W*NUM_FETCH-1:0]                grant_tid_o
);
    import fsel_pkg::*;

    localparam bit SOLO = (NUM_THREADS == 1);

    typedef struct packed {
        logic [NUM_THREADS-1:0][TID_W-1:0] order;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_THREADS-1:0]            elig;
    logic [NUM_THREADS-1:0][CNT_W-1:0] iq_cnt, lsq_cnt, cnt_sel;
    logic [NUM_FETCH-1:0]              rr_valid, occ_valid, gv;
    logic [NUM_FETCH-1:0][TID_W-1:0]   rr_tid, occ_tid, gt;
    logic [NUM_THREADS-1:0][TID_W-1:0] rr_next;

    assign iq_cnt  = iq_cnt_i;
    assign lsq_cnt = lsq_cnt_i;
    assign cnt_sel = (policy_i == POL_LSQ) ? lsq_cnt : iq_cnt;

    fsel_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
        .status_i (status_i),
        .active_i (active_i),
        .elig_o   (elig)
    );

    fsel_rr_pick #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_FETCH   (NUM_FETCH),
        .TID_W       (TID_W)
    ) u_rr (
        .order_i      (state_q.order),
        .elig_i       (elig),
        .valid_o      (rr_valid),
        .tid_o        (rr_tid),
        .order_next_o (rr_next)
    );

    fsel_occ_pick #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_FETCH   (NUM_FETCH),
        .TID_W       (TID_W),
        .CNT_W       (CNT_W)
    ) u_occ (
        .cnt_i   (cnt_sel),
        .elig_i  (elig),
        .valid_o (occ_valid),
        .tid_o   (occ_tid)
    );

    // Grant mux by policy; one-thread configuration bypasses the policy
    always_comb begin
        gv = '0;
        gt = '0;
        if (SOLO) begin
            gv[0] = elig[0];
        end else begin
            case (policy_i)
                POL_SINGLE: gv[0] = 1'b1;
                POL_RR: begin
                    gv = rr_valid;
                    gt = rr_tid;
                end
                default: begin
                    gv = occ_valid;
                    gt = occ_tid;
                end
            endcase
        end
    end

    assign grant_valid_o = gv;
    assign grant_tid_o   = gt;

    // Next-state: order rotates only on round-robin cycles
    always_comb begin
        state_d = state_q;
        if (!SOLO && policy_i == POL_RR) begin
            state_d.order = rr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                state_q.order[t] <= TID_W'(t);
            end
        end else begin
            state_q <= state_d;
        end
    end

    // Checks
    logic [NUM_THREADS-1:0] order_present;
    always_comb begin
        order_present = '0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            order_present[state_q.order[p]] = 1'b1;
        end
    end

    AST_ORDER_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(order_present) == NUM_THREADS); // R4

    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i != POL_RR) |=> $stable(state_q.order)); // R10

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0 && (SOLO || policy_i != POL_SINGLE)) |-> (grant_valid_o == '0)); // R7

    for (genvar k = 0; k < NUM_FETCH; k++) begin : g_chk
        AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            (gv[k] && (SOLO || policy_i != POL_SINGLE)) |-> elig[gt[k]]); // R1
        if (k > 0) begin : g_pack
            AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
                gv[k] |-> gv[k-1]); // R6
            for (genvar j = 0; j < k; j++) begin : g_pair
                AST_SLOTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
                    (gv[k] && gv[j]) |-> (gt[k] != gt[j])); // R6
            end
        end
    end

endmodule

// File: tb/fsel_thread_select_bench.sv
module fsel_thread_select_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT    = 4;
    localparam int NF    = 2;
    localparam int CW    = 6;
    localparam int TW    = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          policy;
    logic [3*NT-1:0]     status;
    logic [NT-1:0]       active;
    logic [CW*NT-1:0]    iq_cnt, lsq_cnt;
    logic [NF-1:0]       gvalid;
    logic [TW*NF-1:0]    gtid;

    logic [1:0]          s_policy;
    logic [2:0]          s_status;
    logic                s_active;
    logic [CW-1:0]       s_cnt;
    logic [NF-1:0]       s_gvalid;
    logic [NF-1:0]       s_gtid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int st[NT];
    bit act[NT];
    int iq[NT];
    int lsq[NT];
    int pol;
    int q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fsel_thread_select #(.NUM_THREADS(NT), .NUM_FETCH(NF), .CNT_W(CW)) u_fsel_thread_select (
        .clk(clk), .rst_n(rst_n), .policy_i(policy), .status_i(status), .active_i(active),
        .iq_cnt_i(iq_cnt), .lsq_cnt_i(lsq_cnt), .grant_valid_o(gvalid), .grant_tid_o(gtid)
    );

    fsel_thread_select #(.NUM_THREADS(1), .NUM_FETCH(NF), .CNT_W(CW)) u_fsel_thread_select_solo (
        .clk(clk), .rst_n(rst_n), .policy_i(s_policy), .status_i(s_status), .active_i(s_active),
        .iq_cnt_i(s_cnt), .lsq_cnt_i(s_cnt), .grant_valid_o(s_gvalid), .grant_tid_o(s_gtid)
    );

    function automatic bit is_elig(int t);
        return act[t] && (st[t] <= 2);
    endfunction

    task automatic drive();
        policy = 2'(pol);
        for (int t = 0; t < NT; t++) begin
            status[3*t +: 3]   = 3'(st[t]);
            active[t]          = act[t];
            iq_cnt[CW*t +: CW] = CW'(iq[t]);
            lsq_cnt[CW*t +: CW] = CW'(lsq[t]);
        end
    endtask

    task automatic check(string tag, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // One cycle: drive at negedge, compare against model, then advance model order
    task automatic step(string tag);
        bit ev[NF];
        int et[NF];
        bit taken[NT];
        int nq[$];
        @(negedge clk);
        drive();
        #1;
        for (int t = 0; t < NT; t++) taken[t] = 0;
        for (int k = 0; k < NF; k++) begin
            ev[k] = 0;
            et[k] = 0;
            if (pol == 0) begin
                if (k == 0) ev[k] = 1;
            end else if (pol == 1) begin
                for (int i = 0; i < q.size(); i++) begin
                    if (!ev[k] && is_elig(q[i]) && !taken[q[i]]) begin
                        ev[k] = 1;
                        et[k] = q[i];
                    end
                end
            end else begin
                int best;
                best = 0;
                for (int t = 0; t < NT; t++) begin
                    int c;
                    c = (pol == 2) ? iq[t] : lsq[t];
                    if (is_elig(t) && !taken[t] && (!ev[k] || c < best)) begin
                        ev[k] = 1;
                        et[k] = t;
                        best  = c;
                    end
                end
            end
            if (ev[k]) taken[et[k]] = 1;
        end
        for (int k = 0; k < NF; k++) begin
            string tg;
            tg = (k == 0) ? tag : "R6";
            check({tg, " valid"}, int'(gvalid[k]), int'(ev[k]));
            check({tg, " tid"}, int'(gtid[TW*k +: TW]), et[k]);
        end
        if (pol == 1) begin
            for (int i = 0; i < q.size(); i++) if (!taken[q[i]]) nq.push_back(q[i]);
            for (int k = 0; k < NF; k++) if (ev[k]) nq.push_back(et[k]);
            q = nq;
        end
    endtask

    function automatic string pol_tag();
        if (pol == 0) return "R8";
        for (int t = 0; t < NT; t++) if (is_elig(t)) return (pol == 1) ? "R3" : "R5";
        return "R7";
    endfunction

    task automatic solo_step(int p, int s, bit a);
        @(negedge clk);
        s_policy = 2'(p);
        s_status = 3'(s);
        s_active = a;
        #1;
        check("R9 valid0", int'(s_gvalid[0]), int'(a && s <= 2));
        check("R9 tid0", int'(s_gtid[0]), 0);
        check("R9 valid1", int'(s_gvalid[1]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pol = 1;
        for (int t = 0; t < NT; t++) begin
            st[t] = 0; act[t] = 0; iq[t] = 0; lsq[t] = 0;
        end
        s_policy = 0; s_status = 0; s_active = 0; s_cnt = 0;
        drive();
        q = {0, 1, 2, 3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Nothing active: no grant
        step("R7");
        // All eligible after reset: ascending order, then rotation
        for (int t = 0; t < NT; t++) act[t] = 1;
        step("R2");
        for (int i = 0; i < 4; i++) step("R4");

        // Ineligible statuses and inactive thread
        st[0] = 3; st[1] = 4; st[2] = 1; st[3] = 5;
        step("R1");
        st[0] = 6; st[1] = 7; st[2] = 2; act[2] = 0; st[3] = 0;
        step("R1");
        act[2] = 1;
        step("R1");

        // Occupancy modes with ties
        for (int t = 0; t < NT; t++) st[t] = 0;
        pol = 2; iq = '{5, 3, 3, 9};
        step("R5");
        pol = 3; lsq = '{0, 7, 0, 1};
        step("R5");
        // Order held outside round-robin, then resumes
        pol = 2;
        repeat (3) step("R10");
        pol = 1;
        for (int t = 0; t < NT; t++) act[t] = 0;
        step("R10");
        for (int t = 0; t < NT; t++) act[t] = 1;
        step("R10");

        // Single-thread mode ignores thread 0 state
        pol = 0; st[0] = 4; act[0] = 0;
        step("R8");
        act[0] = 1; st[0] = 0;
        step("R8");

        // Random mixes
        for (int i = 0; i < 400; i++) begin
            pol = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 3);
            for (int t = 0; t < NT; t++) begin
                st[t]  = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(0, 7);
                act[t] = ($urandom_range(0, 3) != 0);
                iq[t]  = $urandom_range(0, 3);
                lsq[t] = $urandom_range(0, 63);
            end
            step(pol_tag());
        end

        // One-thread configuration bypasses policy
        for (int i = 0; i < 24; i++) begin
            solo_step(i % 4, i % 8, (i % 3) != 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule